// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is a byte-wide, two-way mailbox between a host bus and a small embedded controller CPU. The host writes bytes into an input buffer and reads bytes back from an output buffer. A select bit on every host access chooses between the data path and the command/status path. The CPU reads the input buffer, fills the output buffer and owns a status byte. In that byte, five bits are free for firmware use and three bits are handshake flags.

The handshake flags change only as a side effect of accesses from the opposite side. A host write marks the input buffer full and records whether the byte was a command or data. A CPU read of the input buffer empties it. A CPU write marks the output buffer full, and a host data read empties it. Each direction has an interrupt with its own enable. When a set event and a clear event for the same flag fall in one clock, the set event wins.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset the status byte is 0x00, both buffers hold 0x00 and both interrupts are low.
- R2: A host write (`host_wr`) stores `host_wdata` into the input buffer, which appears on `cpu_ibuf_data` one clock later, and sets the input-full flag at status bit 1.
- R3: On every host write, status bit 3 takes the value of `host_sel`. It is 1 for a command and 0 for data.
- R4: `cpu_ibf_irq` is high exactly while the input-full flag is set and `ibf_irq_en` is high. A CPU read pulse (`cpu_ibuf_rd`) clears the flag and the interrupt on the next clock.
- R5: A CPU write (`cpu_obuf_wr`) loads `cpu_obuf_wdata` into the output buffer and sets the output-full flag at status bit 0.
- R6: `host_kbd_irq` is high exactly while the output-full flag is set and `kbd_irq_en` is high. A host read with `host_sel` low clears the flag and the interrupt on the next clock.
- R7: A CPU status write (`cpu_stat_wr`) updates only bits 7, 6, 5, 4 and 2 from `cpu_stat_wdata`. Bits 0, 1 and 3 ignore it.
- R8: When a set event and a clear event for the same flag fall in the same clock, the flag ends up set.
- R9: A host read with `host_sel` high returns the status byte and changes no flag.
- R10: `host_rdata` shows the status byte while `host_sel` is high and the output buffer while it is low, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host path select: 1 command/status, 0 data |
| host_wr | input | 1 | Host write strobe, one clock per byte |
| host_rd | input | 1 | Host read strobe, one clock per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (status or output buffer) |
| cpu_ibuf_rd | input | 1 | CPU read strobe for the input buffer |
| cpu_ibuf_data | output | 8 | Input buffer contents |
| cpu_obuf_wr | input | 1 | CPU write strobe for the output buffer |
| cpu_obuf_wdata | input | 8 | CPU output buffer byte |
| cpu_stat_wr | input | 1 | CPU write strobe for the free status bits |
| cpu_stat_wdata | input | 8 | CPU status write byte |
| cpu_status | output | 8 | Status byte as seen by the CPU |
| ibf_irq_en | input | 1 | Enable for the CPU input interrupt |
| kbd_irq_en | input | 1 | Enable for the host keyboard interrupt |
| cpu_ibf_irq | output | 1 | CPU interrupt: input buffer full |
| host_kbd_irq | output | 1 | Host interrupt: output buffer full |

## Verification
A flag stuck in the wrong state shows on `cpu_status` and `host_rdata` in the clock right after the access that should have moved it. The interrupt pins show the same error in that clock whenever their enable is high. A wrong set/clear priority only shows when the two events coincide, so the stimulus forces host writes against CPU reads, and CPU writes against host data reads, in the same cycle. A leak of firmware status writes into the handshake bits shows up as a wrong bit 0, 1 or 3 right after a status write of all ones.

// File: rtl/kbc_mbox_pkg.sv
package kbc_mbox_pkg;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned OBF_POS = 0;
  localparam int unsigned IBF_POS = 1;
  localparam int unsigned CD_POS  = 3;

  // bits the firmware owns: all except the three handshake positions
  function automatic logic [STAT_W-1:0] fw_mask();
    logic [STAT_W-1:0] m;
    m = '1;
    m[OBF_POS] = 1'b0;
    m[IBF_POS] = 1'b0;
    m[CD_POS]  = 1'b0;
    return m;
  endfunction

  // set has priority over clear
  function automatic logic flag_next(logic cur, logic set_ev, logic clr_ev);
    if (set_ev)      return 1'b1;
    else if (clr_ev) return 1'b0;
    else             return cur;
  endfunction

  function automatic logic [STAT_W-1:0] build_status(logic [STAT_W-1:0] fw_bits,
                                                     logic cd, logic ibf, logic obf);
    logic [STAT_W-1:0] s;
    s = fw_bits & fw_mask();
    s[CD_POS]  = cd;
    s[IBF_POS] = ibf;
    s[OBF_POS] = obf;
    return s;
  endfunction
endpackage

// File: rtl/kbc_flag_cell.sv
module kbc_flag_cell
  import kbc_mbox_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, set_ev, clr_ev);
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag_q);
  assert_clear_R4_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> !flag_q);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_ev && !clr_ev) |=> $stable(flag_q));
endmodule

// File: rtl/kbc_host_side.sv
module kbc_host_side #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] ibuf_q,
  output logic          cd_q,
  output logic          ibf_set_ev,
  output logic          obf_clr_ev
);
  assign ibf_set_ev = host_wr;
  assign obf_clr_ev = host_rd && !host_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibuf_q <= '0;
      cd_q   <= 1'b0;
    end else if (host_wr) begin
      ibuf_q <= host_wdata;
      cd_q   <= host_sel;
    end
  end

  assert_ibuf_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (ibuf_q == $past(host_wdata)));
  assert_cd_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (cd_q == $past(host_sel)));
  assert_cd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> $stable(cd_q));
endmodule

// File: rtl/kbc_cpu_side.sv
module kbc_cpu_side
  import kbc_mbox_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_ibuf_rd,
  input  logic          cpu_obuf_wr,
  input  logic [DW-1:0] cpu_obuf_wdata,
  input  logic          cpu_stat_wr,
  input  logic [DW-1:0] cpu_stat_wdata,
  output logic [DW-1:0] obuf_q,
  output logic [DW-1:0] fw_q,
  output logic          obf_set_ev,
  output logic          ibf_clr_ev
);
  localparam logic [DW-1:0] FW_MASK = fw_mask();

  assign obf_set_ev = cpu_obuf_wr;
  assign ibf_clr_ev = cpu_ibuf_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf_q <= '0;
      fw_q   <= '0;
    end else begin
      if (cpu_obuf_wr) obuf_q <= cpu_obuf_wdata;
      if (cpu_stat_wr) fw_q   <= cpu_stat_wdata & FW_MASK;
    end
  end

  assert_obuf_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_obuf_wr |=> (obuf_q == $past(cpu_obuf_wdata)));
  assert_fw_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stat_wr |=> $stable(fw_q));
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_mbox_pkg::*;
#(
  parameter int unsigned DW = STAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          cpu_ibuf_rd,
  output logic [DW-1:0] cpu_ibuf_data,
  input  logic          cpu_obuf_wr,
  input  logic [DW-1:0] cpu_obuf_wdata,
  input  logic          cpu_stat_wr,
  input  logic [DW-1:0] cpu_stat_wdata,
  output logic [DW-1:0] cpu_status,
  input  logic          ibf_irq_en,
  input  logic          kbd_irq_en,
  output logic          cpu_ibf_irq,
  output logic          host_kbd_irq
);
  logic [DW-1:0] ibuf_q, obuf_q, fw_q;
  logic          cd_q;
  logic          ibf_set_ev, ibf_clr_ev, obf_set_ev, obf_clr_ev;
  logic          ibf_q, obf_q;
  logic [DW-1:0] status_w;

  kbc_host_side #(.DW(DW)) u_host (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .ibuf_q(ibuf_q), .cd_q(cd_q),
    .ibf_set_ev(ibf_set_ev), .obf_clr_ev(obf_clr_ev)
  );

  kbc_cpu_side #(.DW(DW)) u_cpu (
    .clk(clk), .rst_n(rst_n), .cpu_ibuf_rd(cpu_ibuf_rd), .cpu_obuf_wr(cpu_obuf_wr),
    .cpu_obuf_wdata(cpu_obuf_wdata), .cpu_stat_wr(cpu_stat_wr),
    .cpu_stat_wdata(cpu_stat_wdata), .obuf_q(obuf_q), .fw_q(fw_q),
    .obf_set_ev(obf_set_ev), .ibf_clr_ev(ibf_clr_ev)
  );

  kbc_flag_cell u_ibf (
    .clk(clk), .rst_n(rst_n), .set_ev(ibf_set_ev), .clr_ev(ibf_clr_ev), .flag_q(ibf_q)
  );

  kbc_flag_cell u_obf (
    .clk(clk), .rst_n(rst_n), .set_ev(obf_set_ev), .clr_ev(obf_clr_ev), .flag_q(obf_q)
  );

  assign status_w      = build_status(fw_q, cd_q, ibf_q, obf_q);
  assign cpu_status    = status_w;
  assign cpu_ibuf_data = ibuf_q;
  assign host_rdata    = host_sel ? status_w : obuf_q;
  assign cpu_ibf_irq   = ibf_q && ibf_irq_en;
  assign host_kbd_irq  = obf_q && kbd_irq_en;

  assert_ibf_irq_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ibf_irq |-> cpu_status[IBF_POS]);
  assert_ibf_irq_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ibuf_rd && !host_wr) |=> !cpu_ibf_irq);
  assert_kbd_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_sel && !cpu_obuf_wr) |=> !host_kbd_irq);
  assert_kbd_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_obuf_wr && kbd_irq_en) |=> (host_kbd_irq || !kbd_irq_en));
  assert_status_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel |-> (host_rdata == cpu_status));
endmodule

// File: tb/kbc_mailbox_bench.sv
module kbc_mailbox_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_sel = 0, host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic       cpu_ibuf_rd = 0;
  logic [7:0] cpu_ibuf_data;
  logic       cpu_obuf_wr = 0, cpu_stat_wr = 0;
  logic [7:0] cpu_obuf_wdata = 0, cpu_stat_wdata = 0, cpu_status;
  logic       ibf_irq_en = 0, kbd_irq_en = 0;
  logic       cpu_ibf_irq, host_kbd_irq;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit finished = 0;

  // behavioural reference state
  int m_ibuf = 0, m_obuf = 0, m_fw = 0;
  bit m_ibf = 0, m_obf = 0, m_cd = 0;

  always #5 clk = ~clk;

  kbc_mailbox u_kbc_mailbox (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cpu_ibuf_rd(cpu_ibuf_rd),
    .cpu_ibuf_data(cpu_ibuf_data), .cpu_obuf_wr(cpu_obuf_wr),
    .cpu_obuf_wdata(cpu_obuf_wdata), .cpu_stat_wr(cpu_stat_wr),
    .cpu_stat_wdata(cpu_stat_wdata), .cpu_status(cpu_status), .ibf_irq_en(ibf_irq_en),
    .kbd_irq_en(kbd_irq_en), .cpu_ibf_irq(cpu_ibf_irq), .host_kbd_irq(host_kbd_irq)
  );

  function automatic int model_status();
    // firmware bits live at 7..4 and 2; flags at 3 (cmd), 1 (in full), 0 (out full)
    return (m_fw % 4 == 0 ? m_fw : 0) + (m_cd ? 8 : 0) + (m_ibf ? 2 : 0) + (m_obf ? 1 : 0);
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    cmp("R1/R3/R7", "cpu_status", int'(cpu_status), model_status());
    cmp("R10", "host_rdata", int'(host_rdata), host_sel ? model_status() : m_obuf);
    cmp("R2", "cpu_ibuf_data", int'(cpu_ibuf_data), m_ibuf);
    cmp("R4", "cpu_ibf_irq", int'(cpu_ibf_irq), (m_ibf && ibf_irq_en) ? 1 : 0);
    cmp("R6", "host_kbd_irq", int'(host_kbd_irq), (m_obf && kbd_irq_en) ? 1 : 0);
  endtask

  // one bus cycle: drive at negedge, model at posedge, check at following negedge
  task automatic step(bit sel, bit hwr, bit hrd, int hwd, bit crd, bit cow, int cowd,
                      bit csw, int cswd);
    host_sel = sel; host_wr = hwr; host_rd = hrd; host_wdata = 8'(hwd);
    cpu_ibuf_rd = crd; cpu_obuf_wr = cow; cpu_obuf_wdata = 8'(cowd);
    cpu_stat_wr = csw; cpu_stat_wdata = 8'(cswd);
    @(posedge clk);
    if (hwr) begin m_ibuf = hwd & 255; m_cd = sel; m_ibf = 1; end
    else if (crd) m_ibf = 0;
    if (cow) begin m_obuf = cowd & 255; m_obf = 1; end
    else if (hrd && !sel) m_obf = 0;
    if (csw) m_fw = (cswd & 255) - ((cswd & 255) % 16) + ((cswd & 4) != 0 ? 4 : 0);
    @(negedge clk);
    host_wr = 0; host_rd = 0; cpu_ibuf_rd = 0; cpu_obuf_wr = 0; cpu_stat_wr = 0;
    #1;
    compare_all();
  endtask

  initial begin : watchdog
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state seen while reset is held
    cmp("R1", "status in reset", int'(cpu_status), 0);
    cmp("R1", "irq in reset", int'({cpu_ibf_irq, host_kbd_irq}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    compare_all();

    ibf_irq_en = 1; kbd_irq_en = 1;
    // R2 R3: data write then command write
    step(0, 1, 0, 8'h5A, 0, 0, 0, 0, 0);
    step(1, 1, 0, 8'hC3, 0, 0, 0, 0, 0);
    // R4: CPU consumes the byte
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R5 R6: CPU sends a byte, host reads status (R9: no effect), then data
    step(0, 0, 0, 0, 0, 1, 8'h96, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0, 0);
    // R7: all-ones firmware write must not touch bits 0,1,3
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'hFF);
    step(1, 1, 0, 8'h11, 0, 1, 8'h22, 1, 8'h0B);
    // R8: set and clear in the same cycle for both flags
    step(0, 1, 0, 8'h33, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 1, 8'h44, 0, 0);
    // interrupt enables off: flags still move, interrupts stay low (R4 R6)
    ibf_irq_en = 0; kbd_irq_en = 0;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    ibf_irq_en = 1; kbd_irq_en = 1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 2000; i++) begin
      ibf_irq_en = 1'($urandom_range(0, 1));
      kbd_irq_en = 1'($urandom_range(0, 1));
      step(1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
           int'($urandom_range(0, 255)), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 3) == 0), int'($urandom_range(0, 255)),
           ($urandom_range(0, 7) == 0), int'($urandom_range(0, 255)));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule